// File: doc/BRIEF.md
# Idle and Powerdown Clock Sequencer

This block sits between a microcontroller core and its clock tree and decides which clock domains run. The core issues a one-cycle request strobe with a two-bit mode operand. Operand 1 asks for a light sleep: the CPU clock stops while the peripheral clocks, the oscillator and the watchdog keep going. Operand 2 asks for deep sleep: the oscillator is switched off, both clock domains are held low, the bus strobes are parked inactive and the external clock pin is forced high. Deep sleep is granted only if a permit bit, captured from the nonvolatile configuration store while reset is held, is set.

The sequencer has four states. `PM_RUN` (code 0) is normal operation. `PM_IDLE` (code 1) is light sleep. `PM_PDOWN` (code 2) is deep sleep. `PM_SETTLE` (code 3) lets the oscillator start and settle before clocks restart. The transitions are: RUN to IDLE on an operand-1 request; RUN to PDOWN on an operand-2 request while the permit bit is set; IDLE to RUN on any enabled interrupt or on a watchdog overflow; PDOWN to SETTLE on an enabled external interrupt; SETTLE to RUN once the settle count has elapsed. Reset returns any state to RUN. After an interrupt wake-up, a one-cycle resume pulse tells the core to run its handler and then carry on past the sleep request. Register contents elsewhere are untouched: only outputs are forced.

The watchdog counts in RUN and IDLE while enabled. If the core neither kicks it nor wakes in time, it raises a one-cycle device-reset pulse.

Top module: `pwrmode_ctrl`

## Requirements
- R1: In PM_RUN, a request with operand 1 moves the state to PM_IDLE one clock later. In PM_IDLE, cpu_clk_en is 0 while per_clk_en and osc_en stay 1.
- R2: In PM_IDLE, if any irq_pend bit is set with its irq_en bit set, or ext_int and ext_en are both 1, the state returns to PM_RUN at the next clock and cpu_clk_en is 1 again.
- R3: resume_pulse is 1 for exactly the first PM_RUN cycle after an interrupt wake-up, from PM_IDLE or from PM_SETTLE. It stays 0 after a watchdog wake-up and after reset.
- R4: In PM_IDLE, pending interrupts whose enable is 0, and an external interrupt input held low, leave the state in PM_IDLE with resume_pulse 0.
- R5: When wdt_en is 1, the watchdog counts every cycle in PM_RUN and PM_IDLE, and wdt_kick clears it. wdt_rst is a one-cycle pulse seen exactly WDT_LIMIT clocks after the kick edge when no kick follows. If that happens in PM_IDLE, the state returns to PM_RUN one clock later. WDT_LIMIT defaults to 65536.
- R6: In PM_PDOWN, osc_en, cpu_clk_en and per_clk_en are 0, and bus_idle and clkout_hi are 1. The watchdog neither counts nor overflows there.
- R7: The permit bit follows cfg_pd_in (configuration byte 0, bit 0) only while rst_n is low. Changes of cfg_pd_in after reset release have no effect.
- R8: An operand-2 request while the permit bit is 0 is ignored: the state stays PM_RUN and all clocks stay enabled.
- R9: PM_PDOWN is left only on reset or on ext_int with ext_en. Internal interrupts are ignored. The exit passes through PM_SETTLE, which lasts exactly SETTLE_CYC cycles with osc_en 1 and both clock enables 0, and then enters PM_RUN.
- R10: While rst_n is low, and in the first cycle after it rises, the state is PM_RUN with all clock enables 1, bus_idle and clkout_hi 0, and no pulse on resume_pulse or wdt_rst. Reset works from any state.
- R11: Operands 0 and 3 are ignored, and so are requests made outside PM_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cfg_pd_in | input | 1 | Deep-sleep permit bit from nonvolatile configuration byte 0, bit 0 |
| mode_req | input | 1 | One-cycle sleep request strobe |
| mode_op | input | 2 | Sleep operand: 1 light sleep, 2 deep sleep |
| irq_pend | input | NIRQ | Internal interrupt pending flags |
| irq_en | input | NIRQ | Internal interrupt enables |
| ext_int | input | 1 | Active-high external interrupt |
| ext_en | input | 1 | External interrupt enable |
| wdt_en | input | 1 | Watchdog enable; when 0 the count is held at zero |
| wdt_kick | input | 1 | Watchdog clear |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_idle | output | 1 | Bus-control strobes forced inactive |
| clkout_hi | output | 1 | Clock output pin forced high |
| resume_pulse | output | 1 | One-cycle resume after an interrupt wake-up |
| wdt_rst | output | 1 | One-cycle device reset from watchdog overflow |
| pm_state | output | 2 | Current state: 0 RUN, 1 IDLE, 2 PDOWN, 3 SETTLE |

## Verification
The bench builds the block with NIRQ at 4, WDT_LIMIT at 64 and SETTLE_CYC at 5. The short watchdog interval makes an exact overflow count, and a check that the count is frozen through several intervals of deep sleep, quick to run. The five-cycle settle window allows an exact measure of how long PM_SETTLE lasts. With four interrupt lines, random pending and enable patterns cover both the masked case and the waking case.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_IDLE   = 2'd1,
        PM_PDOWN  = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_e;

    localparam logic [1:0] OP_LIGHT = 2'd1;
    localparam logic [1:0] OP_DEEP  = 2'd2;

endpackage

// File: rtl/pwr_cfg_latch.sv
module pwr_cfg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_in,
    output logic permit
);

    logic permit_q;

    // Follows the configuration bit only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) permit_q <= cfg_in;
    end

    assign permit = permit_q;

    // R7: frozen once reset is released
    a_r7_permit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(permit_q));

endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int NIRQ = 8
) (
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            ext_int,
    input  logic            ext_en,
    output logic            light_wake,
    output logic            deep_wake
);

    logic [NIRQ-1:0] src_hit;

    for (genvar g = 0; g < NIRQ; g++) begin : g_src
        assign src_hit[g] = irq_pend[g] & irq_en[g];
    end

    logic ext_hit;
    assign ext_hit    = ext_int & ext_en;
    assign light_wake = (|src_hit) | ext_hit;
    assign deep_wake  = ext_hit;

    // R9: a deep-sleep wake source is always a light-sleep wake source too
    always_comb begin
        a_r9_deep_subset: assert (!deep_wake || light_wake);
    end

endmodule

// File: rtl/pwr_wdog.sv
module pwr_wdog #(
    parameter int LIMIT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic active,
    input  logic kick,
    output logic overflow
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (!enable || kick) begin
                cnt_q <= '0;
            end else if (active) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign overflow = ovf_q;

    // R5: the reset pulse lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> !overflow);

    // R6: an overflow only follows a cycle in which counting was allowed
    a_r6_counting_state: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(active) && $past(enable));

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwrmode_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] op,
    input  logic       permit,
    input  logic       light_wake,
    input  logic       deep_wake,
    input  logic       wdt_ovf,
    output pm_state_e  state,
    output logic       wdt_active,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       bus_idle,
    output logic       clkout_hi,
    output logic       resume_pulse
);

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    pm_state_e     state_q, state_d;
    logic [SW-1:0] settle_q;
    logic          settle_done;
    logic          resume_q;
    logic          irq_resume;

    assign settle_done = (state_q == PM_SETTLE) && (settle_q == SETTLE_LAST);
    assign irq_resume  = ((state_q == PM_IDLE) && light_wake && !wdt_ovf) || settle_done;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (!wdt_ovf && req) begin
                    if (op == OP_LIGHT)
                        state_d = PM_IDLE;
                    else if (op == OP_DEEP && permit)
                        state_d = PM_PDOWN;
                end
            end
            PM_IDLE: begin
                if (wdt_ovf || light_wake) state_d = PM_RUN;
            end
            PM_PDOWN: begin
                if (deep_wake) state_d = PM_SETTLE;
            end
            PM_SETTLE: begin
                if (settle_done) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    // State register, settle counter and resume flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PM_RUN;
            settle_q <= '0;
            resume_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            resume_q <= irq_resume;
            if (state_q == PM_SETTLE && !settle_done)
                settle_q <= settle_q + 1'b1;
            else
                settle_q <= '0;
        end
    end

    // Output decode
    always_comb begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        osc_en     = 1'b1;
        bus_idle   = 1'b0;
        clkout_hi  = 1'b0;
        wdt_active = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                wdt_active = 1'b1;
            end
            PM_IDLE: begin
                cpu_clk_en = 1'b0;
                wdt_active = 1'b1;
            end
            PM_PDOWN: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = 1'b0;
                bus_idle   = 1'b1;
                clkout_hi  = 1'b1;
            end
            PM_SETTLE: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                bus_idle   = 1'b1;
                clkout_hi  = 1'b1;
            end
            default: begin
                cpu_clk_en = 1'b1;
            end
        endcase
    end

    assign state        = state_q;
    assign resume_pulse = resume_q;

    // R1: a light-sleep request in RUN lands in IDLE
    a_r1_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && req && op == OP_LIGHT && !wdt_ovf) |=> state_q == PM_IDLE);

    // R4: no wake source and no overflow keeps IDLE
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_IDLE && !light_wake && !wdt_ovf) |=> state_q == PM_IDLE);

    // R8: a refused deep-sleep request leaves RUN in place
    a_r8_deep_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && req && op == OP_DEEP && !permit) |=> state_q == PM_RUN);

    // R6: deep sleep is only ever held with the permit bit set
    a_r6_deep_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_PDOWN) |-> permit);

    // R9: PDOWN is left only toward SETTLE, and only on an external wake
    a_r9_deep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_PDOWN && !deep_wake) |=> state_q == PM_PDOWN);

    // R9: SETTLE hands over to RUN only after the full count
    a_r9_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && $past(state_q) == PM_SETTLE) |-> $past(settle_q) == SETTLE_LAST);

    // R3: resume lasts one cycle and is seen in RUN
    a_r3_resume_once: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);
    a_r3_resume_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> state_q == PM_RUN);

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int NIRQ       = 8,
    parameter int WDT_LIMIT  = 65536,
    parameter int SETTLE_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_pd_in,
    input  logic            mode_req,
    input  logic [1:0]      mode_op,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            ext_int,
    input  logic            ext_en,
    input  logic            wdt_en,
    input  logic            wdt_kick,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            osc_en,
    output logic            bus_idle,
    output logic            clkout_hi,
    output logic            resume_pulse,
    output logic            wdt_rst,
    output logic [1:0]      pm_state
);

    logic      permit;
    logic      light_wake;
    logic      deep_wake;
    logic      wdt_active;
    pm_state_e state;

    pwr_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_pd_in),
        .permit (permit)
    );

    pwr_wake_detect #(.NIRQ(NIRQ)) u_wake (
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .ext_int    (ext_int),
        .ext_en     (ext_en),
        .light_wake (light_wake),
        .deep_wake  (deep_wake)
    );

    pwr_wdog #(.LIMIT(WDT_LIMIT)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (wdt_en),
        .active   (wdt_active),
        .kick     (wdt_kick),
        .overflow (wdt_rst)
    );

    pwr_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (mode_req),
        .op           (mode_op),
        .permit       (permit),
        .light_wake   (light_wake),
        .deep_wake    (deep_wake),
        .wdt_ovf      (wdt_rst),
        .state        (state),
        .wdt_active   (wdt_active),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_en       (osc_en),
        .bus_idle     (bus_idle),
        .clkout_hi    (clkout_hi),
        .resume_pulse (resume_pulse)
    );

    assign pm_state = state;

    // R10: out of reset the block always starts with every clock running
    a_r10_reset_run: assert property (@(posedge clk)
        !rst_n |=> (pm_state == 2'd0 && cpu_clk_en && osc_en && !wdt_rst && !resume_pulse));

endmodule

// File: tb/test_pwrmode_ctrl.sv
module test_pwrmode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 4;
    localparam int WDT_LIMIT  = 64;
    localparam int SETTLE_CYC = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_pd_in;
    logic            mode_req;
    logic [1:0]      mode_op;
    logic [NIRQ-1:0] irq_pend;
    logic [NIRQ-1:0] irq_en;
    logic            ext_int;
    logic            ext_en;
    logic            wdt_en;
    logic            wdt_kick;
    logic            cpu_clk_en, per_clk_en, osc_en, bus_idle, clkout_hi;
    logic            resume_pulse, wdt_rst;
    logic [1:0]      pm_state;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pwrmode_ctrl #(.NIRQ(NIRQ), .WDT_LIMIT(WDT_LIMIT), .SETTLE_CYC(SETTLE_CYC)) i_pwrmode_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_pd_in(cfg_pd_in), .mode_req(mode_req), .mode_op(mode_op),
        .irq_pend(irq_pend), .irq_en(irq_en), .ext_int(ext_int), .ext_en(ext_en),
        .wdt_en(wdt_en), .wdt_kick(wdt_kick), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .bus_idle(bus_idle), .clkout_hi(clkout_hi), .resume_pulse(resume_pulse),
        .wdt_rst(wdt_rst), .pm_state(pm_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit exp_wake(logic [NIRQ-1:0] p, logic [NIRQ-1:0] e, logic x, logic xe);
        return (|(p & e)) || (x && xe);
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_run(input string tag);
        chk({tag, " state"}, pm_state, 0);
        chk({tag, " cpu_clk_en"}, cpu_clk_en, 1);
        chk({tag, " per_clk_en"}, per_clk_en, 1);
        chk({tag, " osc_en"}, osc_en, 1);
        chk({tag, " bus_idle"}, bus_idle, 0);
        chk({tag, " clkout_hi"}, clkout_hi, 0);
    endtask

    task automatic request(input logic [1:0] op);
        mode_req = 1'b1;
        mode_op  = op;
        cyc();
        mode_req = 1'b0;
        mode_op  = 2'd0;
    endtask

    task automatic do_reset(input logic pd);
        rst_n     = 1'b0;
        cfg_pd_in = pd;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        cfg_pd_in = ~pd;   // R7: later changes must not matter
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int n;
        int seen;
        logic [NIRQ-1:0] p, e;
        logic x, xe;

        rst_n = 1'b0; cfg_pd_in = 1'b1; mode_req = 1'b0; mode_op = 2'd0;
        irq_pend = '0; irq_en = '0; ext_int = 1'b0; ext_en = 1'b0;
        wdt_en = 1'b0; wdt_kick = 1'b0;
        seed = $urandom(32'd2024);
        cyc();

        // R10: reset state
        do_reset(1'b1);
        chk_run("R10 reset");
        chk("R10 resume", resume_pulse, 0);
        chk("R10 wdt_rst", wdt_rst, 0);

        // R11: unused operands
        request(2'd0);
        chk("R11 op0 state", pm_state, 0);
        request(2'd3);
        chk("R11 op3 state", pm_state, 0);

        // R1, R2, R3, R4: random light-sleep trials
        for (int t = 0; t < 30; t++) begin
            request(2'd1);
            chk("R1 state", pm_state, 1);
            chk("R1 cpu_clk_en", cpu_clk_en, 0);
            chk("R1 per_clk_en", per_clk_en, 1);
            chk("R1 osc_en", osc_en, 1);
            if (t == 0) begin
                request(2'd2);
                chk("R11 request in idle", pm_state, 1);
            end
            p  = NIRQ'($urandom);
            e  = NIRQ'($urandom);
            x  = 1'($urandom);
            xe = 1'($urandom);
            if (t % 3 == 0) begin
                e = ~p;
                x = 1'b0;
                xe = 1'b1;
            end
            irq_pend = p; irq_en = e; ext_int = x; ext_en = xe;
            cyc();
            if (!exp_wake(p, e, x, xe)) begin
                chk("R4 masked stays idle", pm_state, 1);
                chk("R4 no resume", resume_pulse, 0);
                irq_pend = 4'b0010; irq_en = 4'b0010;
                cyc();
            end
            chk("R2 wake state", pm_state, 0);
            chk("R2 cpu_clk_en", cpu_clk_en, 1);
            chk("R3 resume high", resume_pulse, 1);
            irq_pend = '0; irq_en = '0; ext_int = 1'b0; ext_en = 1'b0;
            cyc();
            chk("R3 resume low", resume_pulse, 0);
        end

        // R6, R7, R9: deep sleep (permit captured as 1, input now 0)
        request(2'd2);
        chk("R7 permit kept", pm_state, 2);
        chk("R6 osc_en", osc_en, 0);
        chk("R6 cpu_clk_en", cpu_clk_en, 0);
        chk("R6 per_clk_en", per_clk_en, 0);
        chk("R6 bus_idle", bus_idle, 1);
        chk("R6 clkout_hi", clkout_hi, 1);
        irq_pend = '1; irq_en = '1; ext_en = 1'b1; ext_int = 1'b0;
        repeat (5) cyc();
        chk("R9 internal irq ignored", pm_state, 2);
        ext_en = 1'b0; ext_int = 1'b1;
        cyc();
        chk("R9 disabled ext ignored", pm_state, 2);
        ext_en = 1'b1;
        cyc();
        chk("R9 settle state", pm_state, 3);
        chk("R9 settle osc_en", osc_en, 1);
        chk("R9 settle cpu_clk_en", cpu_clk_en, 0);
        chk("R9 settle per_clk_en", per_clk_en, 0);
        irq_pend = '0; irq_en = '0; ext_int = 1'b0; ext_en = 1'b0;
        n = 1;
        while (pm_state == 2'd3 && n < 100) begin
            cyc();
            if (pm_state == 2'd3) n++;
        end
        chk("R9 settle length", n, SETTLE_CYC);
        chk("R9 back to run", pm_state, 0);
        chk("R3 resume after deep", resume_pulse, 1);
        cyc();
        chk("R3 resume low after deep", resume_pulse, 0);

        // R6: watchdog frozen in deep sleep
        wdt_en = 1'b1; wdt_kick = 1'b1;
        request(2'd2);
        wdt_kick = 1'b0;
        chk("R6 deep again", pm_state, 2);
        seen = 0;
        repeat (3 * WDT_LIMIT) begin
            cyc();
            if (wdt_rst) seen++;
        end
        chk("R6 no overflow in deep", seen, 0);
        wdt_en = 1'b0; ext_int = 1'b1; ext_en = 1'b1;
        cyc();
        ext_int = 1'b0; ext_en = 1'b0;
        repeat (SETTLE_CYC) cyc();
        chk("R9 run after settle", pm_state, 0);

        // R5: regular kicks keep the watchdog quiet
        wdt_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            wdt_kick = (i % 30 == 0);
            cyc();
            if (wdt_rst) seen++;
        end
        wdt_kick = 1'b0;
        chk("R5 kicked no overflow", seen, 0);

        // R5: overflow while idle with no interrupt
        wdt_kick = 1'b1;
        request(2'd1);
        wdt_kick = 1'b0;
        n = 0;
        seen = 0;
        while (!wdt_rst && n < 10 * WDT_LIMIT) begin
            cyc();
            n++;
            if (pm_state != 2'd1 && !wdt_rst) seen++;
        end
        chk("R5 overflow interval", n, WDT_LIMIT);
        chk("R4 idle held until overflow", seen, 0);
        cyc();
        chk("R5 run after overflow", pm_state, 0);
        chk("R5 pulse one cycle", wdt_rst, 0);
        chk("R3 no resume on watchdog", resume_pulse, 0);
        wdt_en = 1'b0;

        // R10: reset from idle, permit captured as 0
        request(2'd1);
        chk("R1 idle before reset", pm_state, 1);
        do_reset(1'b0);
        chk_run("R10 reset from idle");

        // R8, R7: refused deep sleep
        request(2'd2);
        chk_run("R8 refused");
        repeat (3) cyc();
        chk("R8 still run", pm_state, 0);
        request(2'd2);
        chk("R7 late cfg ignored", pm_state, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule